// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit executes the rotate-right instructions of a 64-bit integer pipeline. Each cycle that `in_valid` is high it takes a 32-bit instruction word and the two source operand values (the value of the first source register, `src_a`, and the value of the second source register, `src_b`). It recognises five rotate encodings: a 32-bit (word) rotate with an immediate or a register amount, and a 64-bit (doubleword) rotate with an immediate amount, an immediate amount plus 32, or a register amount.

The rotated value, the destination register index and a write-enable appear one clock cycle later together with an `out_valid` pulse. A word rotate works on the low 32 bits of `src_b` and sign-extends its 32-bit result to 64 bits. Register amounts are masked to the operand width, never range-checked. An instruction word that is not one of the five rotates is flagged illegal and writes nothing, and a destination of register zero never produces a write.

Top module: `rot_exec`

## Requirements
Instruction fields: bits [31:26] primary opcode, [25:21] first source index, [20:16] second source index, [15:11] destination index, [10:6] shift field, [5:0] function code. Every rotate needs primary opcode 000000.
- R1: Word rotate by immediate (first-source field 00001, function 000010) rotates `src_b[31:0]` right by the 5-bit shift field.
- R2: Word rotate by register (shift field 00001, function 000110) rotates `src_b[31:0]` right by `src_a[4:0]`; higher bits of `src_a` have no effect.
- R3: Doubleword rotate by immediate (first-source field 00001, function 111010) rotates all 64 bits of `src_b` right by the shift field (0 to 31).
- R4: Doubleword rotate by immediate plus 32 (first-source field 00001, function 111110) rotates all 64 bits of `src_b` right by the shift field plus 32 (32 to 63).
- R5: Doubleword rotate by register (shift field 00001, function 010110) rotates all 64 bits of `src_b` right by `src_a[5:0]`; higher bits of `src_a` have no effect.
- R6: Any other instruction word gives `out_illegal` = 1, `out_wen` = 0 and `out_data` = 0.
- R7: A destination index of 0 gives `out_wen` = 0 while the result is still produced; otherwise a legal rotate gives `out_wen` = 1.
- R8: Outputs update only on a cycle with `in_valid`, one cycle later, with `out_valid` high for exactly that one cycle; without `in_valid` the data, index, write-enable and illegal outputs hold their values.
- R9: After reset `out_valid`, `out_wen`, `out_illegal`, `out_rd` and `out_data` are all 0.
- R10: The 64-bit result of a word rotate is its 32-bit rotated value sign-extended (bits 63:32 equal bit 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First source value (register rotate amount) |
| src_b | input | 64 | Second source value (value to rotate) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Rotated result |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Register write-enable |
| out_illegal | output | 1 | Instruction word is not a rotate |

## Verification
The hardest cases to reach are the ones that sit next to a legal encoding: words that differ from a rotate only in the fixed 00001 field or the opcode, register amounts whose masked-off upper bits are set, and a legal rotate with destination zero. Purely random instruction words almost never hit a rotate, so the stimulus builds each of the five encodings from random field values, then corrupts one fixed field on purpose, forces destination zero and amounts at 0, 31, 32 and 63, and mixes in fully random words for the illegal path.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int XLEN  = 64;
    localparam int WLEN  = 32;
    localparam int ILEN  = 32;
    localparam int RIDX  = 5;
    localparam int XAMT  = $clog2(XLEN);
    localparam int WAMT  = $clog2(WLEN);

    localparam logic [5:0] OPC_SPECIAL = 6'b000000;
    localparam logic [4:0] FIXED_ONE   = 5'b00001;
    localparam logic [5:0] FN_W_IMM    = 6'b000010;
    localparam logic [5:0] FN_W_REG    = 6'b000110;
    localparam logic [5:0] FN_D_IMM    = 6'b111010;
    localparam logic [5:0] FN_D_IMM32  = 6'b111110;
    localparam logic [5:0] FN_D_REG    = 6'b010110;

    typedef enum logic [2:0] {
        ROT_NONE,
        ROT_W_IMM,
        ROT_W_REG,
        ROT_D_IMM,
        ROT_D_IMM32,
        ROT_D_REG
    } rot_op_e;

    typedef struct packed {
        logic [5:0] opc;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] sa;
        logic [5:0] fn;
    } rot_instr_t;

    typedef struct packed {
        rot_op_e         op;
        logic            legal;
        logic            word;
        logic [RIDX-1:0] rd;
        logic [XAMT-1:0] amt;
    } rot_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] data;
        logic [RIDX-1:0] rd;
        logic            wen;
        logic            illegal;
        logic            word;
    } rot_res_t;

    function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    input  logic [XAMT-1:0] reg_amt,
    output rot_dec_t        dec
);
    rot_instr_t f;
    logic       special;
    logic       rs_one;
    logic       sa_one;

    assign f       = rot_instr_t'(instr);
    assign special = (f.opc == OPC_SPECIAL);
    assign rs_one  = (f.rs == FIXED_ONE);
    assign sa_one  = (f.sa == FIXED_ONE);

    always_comb begin
        dec.op = ROT_NONE;
        if (special) begin
            unique case (f.fn)
                FN_W_IMM:   if (rs_one) dec.op = ROT_W_IMM;
                FN_W_REG:   if (sa_one) dec.op = ROT_W_REG;
                FN_D_IMM:   if (rs_one) dec.op = ROT_D_IMM;
                FN_D_IMM32: if (rs_one) dec.op = ROT_D_IMM32;
                FN_D_REG:   if (sa_one) dec.op = ROT_D_REG;
                default:    dec.op = ROT_NONE;
            endcase
        end
    end

    always_comb begin
        dec.legal = (dec.op != ROT_NONE);
        dec.word  = (dec.op == ROT_W_IMM) || (dec.op == ROT_W_REG);
        dec.rd    = f.rd;
        unique case (dec.op)
            ROT_W_IMM:   dec.amt = {1'b0, f.sa};
            ROT_W_REG:   dec.amt = {1'b0, reg_amt[WAMT-1:0]};
            ROT_D_IMM:   dec.amt = {1'b0, f.sa};
            ROT_D_IMM32: dec.amt = {1'b1, f.sa};
            ROT_D_REG:   dec.amt = reg_amt;
            default:     dec.amt = '0;
        endcase
    end

endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][S-1:0], stage[k][W-1:S]} : stage[k];
    end

    assign dout = stage[SW];

endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
    import rot_pkg::*;
(
    input  rot_dec_t        dec,
    input  logic [XLEN-1:0] val,
    output rot_res_t        res
);
    logic [WLEN-1:0] word_out;
    logic [XLEN-1:0] dbl_out;

    rot_barrel #(.W(WLEN)) u_word (
        .din  (val[WLEN-1:0]),
        .amt  (dec.amt[WAMT-1:0]),
        .dout (word_out)
    );

    rot_barrel #(.W(XLEN)) u_dbl (
        .din  (val),
        .amt  (dec.amt),
        .dout (dbl_out)
    );

    always_comb begin
        if (!dec.legal)
            res.data = '0;
        else if (dec.word)
            res.data = sext_word(word_out);
        else
            res.data = dbl_out;
        res.rd      = dec.rd;
        res.wen     = dec.legal && (dec.rd != '0);
        res.illegal = !dec.legal;
        res.word    = dec.word;
    end

endmodule

// File: rtl/rot_exec.sv
module rot_exec
    import rot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            out_valid,
    output logic [XLEN-1:0] out_data,
    output logic [RIDX-1:0] out_rd,
    output logic            out_wen,
    output logic            out_illegal
);
    rot_dec_t dec;
    rot_res_t res;
    rot_res_t res_q;
    logic     vld_q;

    rot_decode u_dec (
        .instr   (instr),
        .reg_amt (src_a[XAMT-1:0]),
        .dec     (dec)
    );

    rot_datapath u_dp (
        .dec (dec),
        .val (src_b),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= res;
        end
    end

    assign out_valid   = vld_q;
    assign out_data    = res_q.data;
    assign out_rd      = res_q.rd;
    assign out_wen     = res_q.wen;
    assign out_illegal = res_q.illegal;

    // R8: one-cycle latency and single-cycle valid pulse
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8: outputs hold when nothing is accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_rd) && $stable(out_wen) && $stable(out_illegal)));
    // R6: an illegal word never writes and yields zero
    a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_wen && out_data == '0));
    // R7: register zero is never written
    a_r7_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_rd != '0));
    // R10: word results are sign-extended
    a_r10_word_sext: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_q.word) |-> (out_data[XLEN-1:WLEN] == {(XLEN-WLEN){out_data[WLEN-1]}}));

endmodule

// File: tb/rot_exec_test.sv
module rot_exec_test;
    import rot_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        out_valid;
    logic [63:0] out_data;
    logic [4:0]  out_rd;
    logic        out_wen;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rot_exec uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_data(out_data), .out_rd(out_rd), .out_wen(out_wen),
        .out_illegal(out_illegal)
    );

    function automatic logic [63:0] ror64(logic [63:0] x, int n);
        logic [63:0] r = x;
        for (int i = 0; i < n; i++) r = {r[0], r[63:1]};
        return r;
    endfunction

    function automatic logic [31:0] ror32(logic [31:0] x, int n);
        logic [31:0] r = x;
        for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
        return r;
    endfunction

    // kind: 0 none, 1..5 as listed in requirements R1..R5
    function automatic int kind_of(logic [31:0] w);
        if (w[31:26] != 6'd0) return 0;
        if (w[5:0] == 6'b000010 && w[25:21] == 5'd1) return 1;
        if (w[5:0] == 6'b000110 && w[10:6]  == 5'd1) return 2;
        if (w[5:0] == 6'b111010 && w[25:21] == 5'd1) return 3;
        if (w[5:0] == 6'b111110 && w[25:21] == 5'd1) return 4;
        if (w[5:0] == 6'b010110 && w[10:6]  == 5'd1) return 5;
        return 0;
    endfunction

    function automatic logic [63:0] exp_data(logic [31:0] w, logic [63:0] a, logic [63:0] b);
        logic [31:0] t;
        case (kind_of(w))
            1: begin t = ror32(b[31:0], int'(w[10:6])); return {{32{t[31]}}, t}; end
            2: begin t = ror32(b[31:0], int'(a[4:0]));  return {{32{t[31]}}, t}; end
            3: return ror64(b, int'(w[10:6]));
            4: return ror64(b, int'(w[10:6]) + 32);
            5: return ror64(b, int'(a[5:0]));
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic [31:0] mk(int kind, logic [4:0] rt, logic [4:0] rd, logic [4:0] sa, logic [4:0] rs);
        case (kind)
            1: return {6'd0, 5'd1, rt, rd, sa, 6'b000010};
            2: return {6'd0, rs, rt, rd, 5'd1, 6'b000110};
            3: return {6'd0, 5'd1, rt, rd, sa, 6'b111010};
            4: return {6'd0, 5'd1, rt, rd, sa, 6'b111110};
            default: return {6'd0, rs, rt, rd, 5'd1, 6'b010110};
        endcase
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(int k);
        case (k)
            1: return "R1"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; default: return "R6";
        endcase
    endfunction

    task automatic run(logic [31:0] w, logic [63:0] a, logic [63:0] b);
        int k = kind_of(w);
        logic [63:0] ed = exp_data(w, a, b);
        logic ew = (k != 0) && (w[15:11] != 5'd0);
        logic [63:0] hd; logic [4:0] hr; logic hw, hi;
        @(negedge clk);
        instr = w; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        instr = $urandom; src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
        check("R8", "out_valid", 64'(out_valid), 64'd1);
        check(req_of(k), "data", out_data, ed);
        check(req_of(k), "illegal", 64'(out_illegal), 64'(k == 0));
        check(k != 0 && w[15:11] == 0 ? "R7" : req_of(k), "wen", 64'(out_wen), 64'(ew));
        if (k != 0) check("R7", "rd", 64'(out_rd), 64'(w[15:11]));
        if (k == 1 || k == 2) check("R10", "sext", out_data[63:32], {32{out_data[31]}});
        hd = out_data; hr = out_rd; hw = out_wen; hi = out_illegal;
        @(negedge clk);
        check("R8", "pulse", 64'(out_valid), 64'd0);
        check("R8", "hold", out_data ^ hd, 64'd0);
        check("R8", "holdctl", 64'({out_rd, out_wen, out_illegal}), 64'({hr, hw, hi}));
    endtask

    initial begin
        void'($urandom(1234));
        rst = 1'b1; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "valid", 64'(out_valid), 0);
        check("R9", "wen", 64'(out_wen), 0);
        check("R9", "illegal", 64'(out_illegal), 0);
        check("R9", "rd", 64'(out_rd), 0);
        check("R9", "data", out_data, 0);

        // directed corners
        run(mk(1, 5'd3, 5'd4, 5'd0,  5'd0), 0, 64'h1234_5678_8000_0001);     // R1 amount 0
        run(mk(1, 5'd3, 5'd4, 5'd31, 5'd0), 0, 64'hFFFF_0000_0000_0001);     // R1 amount 31
        run(mk(1, 5'd3, 5'd4, 5'd1,  5'd0), 0, 64'h0000_0000_0000_0001);     // R10 negative
        run(mk(2, 5'd3, 5'd5, 5'd0,  5'd7), 64'hFFFF_FFFF_FFFF_FFE4, 64'h0000_0000_F0F0_1234); // R2 mask
        run(mk(3, 5'd3, 5'd6, 5'd0,  5'd0), 0, 64'h8000_0000_0000_0001);     // R3 zero
        run(mk(3, 5'd3, 5'd6, 5'd31, 5'd0), 0, 64'h0123_4567_89AB_CDEF);     // R3 31
        run(mk(4, 5'd3, 5'd6, 5'd0,  5'd0), 0, 64'h0123_4567_89AB_CDEF);     // R4 32
        run(mk(4, 5'd3, 5'd6, 5'd31, 5'd0), 0, 64'h0123_4567_89AB_CDEF);     // R4 63
        run(mk(5, 5'd3, 5'd7, 5'd0,  5'd2), 64'hABCD_0000_0000_00C5, 64'h0123_4567_89AB_CDEF); // R5 mask
        run(mk(3, 5'd3, 5'd0, 5'd9,  5'd0), 0, 64'hDEAD_BEEF_0000_1111);     // R7 rd zero
        run(mk(1, 5'd3, 5'd8, 5'd4, 5'd0) | 32'h0040_0000, 0, 64'h55);       // R6 rs field 00011
        run(mk(5, 5'd3, 5'd8, 5'd0, 5'd1) | 32'h0000_0080, 64'h3, 64'h55);   // R6 shift field 00011
        run(mk(4, 5'd3, 5'd8, 5'd2, 5'd0) | 32'h0400_0000, 0, 64'h55);       // R6 opcode
        run(32'h0000_0000, 0, 64'h55);                                        // R6 all zero

        // random mix
        for (int i = 0; i < 400; i++) begin
            int kind = int'($urandom_range(0, 6));
            logic [31:0] w;
            if (kind == 0) w = $urandom;
            else begin
                w = mk(kind > 5 ? 5 : kind, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
                if ($urandom_range(0, 7) == 0) w[15:11] = 5'd0;
                if ($urandom_range(0, 9) == 0) w = w ^ (32'd1 << $urandom_range(0, 31));
            end
            run(w, {$urandom, $urandom}, {$urandom, $urandom});
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule